// File: doc/BRIEF.md
# Attribute Text Pixel Generator

This block is the per-cell pixel path of a character-based display. For each accepted cell it takes a character code, an attribute byte, the scan line within the cell and the current blink phase. It builds the video RAM byte address of that glyph row and issues one read. When the row byte comes back, it applies the cell's attribute effects and shifts out eight pixels, one per clock. Each pixel is a 4-bit RGBI colour.

Attribute bits 3:0 give the cell's foreground colour. One global 4-bit value gives the background colour. The high nibble of the attribute holds four flags: blink, underline, reverse and alternate glyph set. Each glyph takes a 16-byte record in RAM, with one byte per scan line. A 9-bit glyph index selects one of 512 glyphs. The upper address bits come from a 3-bit glyph base. A new cell is accepted only when the previous cell's eight pixels are done.

Top module: `attr_text_pixgen`

## Requirements
- R1: After reset, rd_req_o and pix_valid_o are low and cell_ready_o is high.
- R2: The read address is {glyph_base_i[2:0], attr_i[7], char_code_i[7:0], scan_line_i[3:0]}. Attribute bit 7 adds 256 to the glyph index, so code 65 selects glyph 321.
- R3: Each cell accepted while cell_ready_o is high raises rd_req_o for exactly one cycle, in the cycle after acceptance. The block then waits for rd_valid_i. cell_ready_o stays low until the cell's last pixel has been shifted out.
- R4: On the clock edge where rd_valid_i is high, the row is loaded. From the next cycle on, pix_valid_o is high for 8 consecutive cycles. Those cycles carry row bits 7 down to 0 in turn: bit value 1 gives foreground attr_i[3:0] and bit value 0 gives bg_color_i. Both colours are captured when the cell is accepted.
- R5: With attribute bit 5 set, on the scan line where the zero-extended scan_line_i equals ul_line_i, the row is forced to all ones before reverse is applied.
- R6: With attribute bit 6 set, the row is inverted. This happens after the underline step.
- R7: With attribute bit 4 set and blink_on_i low when the cell is accepted, all 8 pixels are background, whatever the other flags are.
- R8: A ul_line_i value of 16 or more matches no scan line, so it causes no underline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_valid_i | input | 1 | A cell is offered |
| cell_ready_o | output | 1 | Block can accept a cell |
| char_code_i | input | 8 | Character code |
| attr_i | input | 8 | Attribute byte: 7 alt set, 6 reverse, 5 underline, 4 blink, 3:0 foreground |
| scan_line_i | input | 4 | Scan line within the cell |
| blink_on_i | input | 1 | Blink phase; high means blinking cells are visible |
| glyph_base_i | input | 3 | Upper glyph address bits |
| bg_color_i | input | 4 | Global background colour |
| ul_line_i | input | 5 | Underline scan line |
| rd_req_o | output | 1 | Glyph row read request |
| rd_addr_o | output | 16 | Glyph row byte address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Glyph row byte |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_rgbi_o | output | 4 | Pixel colour, RGBI |

## Verification
The hardest part to reach is where the attribute effects interact: underline combined with reverse on the matching line, and blink combined with both of them. The order of these steps only shows up when several flags are set on the same scan line. The stimulus therefore sweeps all 16 flag combinations over all 16 scan lines, in both blink phases and for three character codes. The RAM model returns an address-dependent byte, so every row pattern differs. A final sweep sets the underline line out of range to confirm that it never matches.

// File: rtl/attr_text_pkg.sv
package attr_text_pkg;
  localparam int CODE_W  = 8;
  localparam int LINE_W  = 4;
  localparam int BASE_W  = 3;
  localparam int COLOR_W = 4;
  localparam int UL_W    = 5;
  localparam int ROW_W   = 8;
  localparam int ADDR_W  = BASE_W + 1 + CODE_W + LINE_W;

  localparam int ATTR_ALT = 7;
  localparam int ATTR_REV = 6;
  localparam int ATTR_UL  = 5;
  localparam int ATTR_BLK = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } pix_state_e;
endpackage

// File: rtl/glyph_addr_gen.sv
module glyph_addr_gen
  import attr_text_pkg::*;
(
  input  logic [BASE_W-1:0] base_i,
  input  logic              alt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CODE_W:0] glyph_idx;
  assign glyph_idx = {alt_i, code_i};
  assign addr_o    = {base_i, glyph_idx, line_i};
endmodule

// File: rtl/row_shaper.sv
module row_shaper
  import attr_text_pkg::*;
(
  input  logic [ROW_W-1:0]  row_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [UL_W-1:0]   ul_line_i,
  input  logic              ul_en_i,
  input  logic              rev_en_i,
  input  logic              blank_i,
  output logic [ROW_W-1:0]  row_o
);
  logic ul_hit;
  logic [ROW_W-1:0] ul_row, rev_row;

  assign ul_hit  = ul_en_i && (ul_line_i == UL_W'(line_i));
  assign ul_row  = ul_hit ? {ROW_W{1'b1}} : row_i;
  assign rev_row = rev_en_i ? ~ul_row : ul_row;
  assign row_o   = blank_i ? '0 : rev_row;
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter
  import attr_text_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COLOR_W-1:0] fg_i,
  input  logic [COLOR_W-1:0] bg_i,
  output logic               active_o,
  output logic               last_o,
  output logic [COLOR_W-1:0] pix_o
);
  localparam int CNT_W = $clog2(ROW_W);

  logic [ROW_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= row_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      sh_q  <= {sh_q[ROW_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(ROW_W-1)) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign last_o   = act_q && (cnt_q == CNT_W'(ROW_W-1));
  assign pix_o    = sh_q[ROW_W-1] ? fg_i : bg_i;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_q); // R4
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !last_o) |=> act_q); // R4
endmodule

// File: rtl/attr_text_pixgen.sv
module attr_text_pixgen
  import attr_text_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cell_valid_i,
  output logic                cell_ready_o,
  input  logic [CODE_W-1:0]   char_code_i,
  input  logic [7:0]          attr_i,
  input  logic [LINE_W-1:0]   scan_line_i,
  input  logic                blink_on_i,
  input  logic [BASE_W-1:0]   glyph_base_i,
  input  logic [COLOR_W-1:0]  bg_color_i,
  input  logic [UL_W-1:0]     ul_line_i,
  output logic                rd_req_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic                rd_valid_i,
  input  logic [ROW_W-1:0]    rd_data_i,
  output logic                pix_valid_o,
  output logic [COLOR_W-1:0]  pix_rgbi_o
);
  pix_state_e state_q;

  logic [CODE_W-1:0]  code_q;
  logic [7:0]         attr_q;
  logic [LINE_W-1:0]  line_q;
  logic [BASE_W-1:0]  base_q;
  logic [COLOR_W-1:0] bg_q;
  logic [UL_W-1:0]    ul_q;
  logic               blank_q;

  logic               accept, load, last;
  logic [ROW_W-1:0]   shaped_row;
  logic               sh_active;

  assign accept = (state_q == ST_IDLE) && cell_valid_i;
  assign load   = (state_q == ST_WAIT) && rd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      attr_q  <= '0;
      line_q  <= '0;
      base_q  <= '0;
      bg_q    <= '0;
      ul_q    <= '0;
      blank_q <= 1'b0;
    end else if (accept) begin
      code_q  <= char_code_i;
      attr_q  <= attr_i;
      line_q  <= scan_line_i;
      base_q  <= glyph_base_i;
      bg_q    <= bg_color_i;
      ul_q    <= ul_line_i;
      blank_q <= attr_i[ATTR_BLK] && !blink_on_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_REQ;
        ST_REQ:   state_q <= ST_WAIT;
        ST_WAIT:  if (load) state_q <= ST_SHIFT;
        ST_SHIFT: if (last) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  glyph_addr_gen u_addr (
    .base_i (base_q),
    .alt_i  (attr_q[ATTR_ALT]),
    .code_i (code_q),
    .line_i (line_q),
    .addr_o (rd_addr_o)
  );

  row_shaper u_shape (
    .row_i     (rd_data_i),
    .line_i    (line_q),
    .ul_line_i (ul_q),
    .ul_en_i   (attr_q[ATTR_UL]),
    .rev_en_i  (attr_q[ATTR_REV]),
    .blank_i   (blank_q),
    .row_o     (shaped_row)
  );

  pixel_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .row_i    (shaped_row),
    .fg_i     (attr_q[COLOR_W-1:0]),
    .bg_i     (bg_q),
    .active_o (sh_active),
    .last_o   (last),
    .pix_o    (pix_rgbi_o)
  );

  assign cell_ready_o = (state_q == ST_IDLE);
  assign rd_req_o     = (state_q == ST_REQ);
  assign pix_valid_o  = sh_active;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o); // R3
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> $past(cell_ready_o && cell_valid_i)); // R3
  AST_ADDR_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[ADDR_W-1 -: BASE_W] == base_q); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !cell_ready_o); // R3
  AST_BLANK_BG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && blank_q) |-> pix_rgbi_o == bg_q); // R7
endmodule

// File: tb/attr_text_pixgen_tb_top.sv
module attr_text_pixgen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_valid = 1'b0;
  logic cell_ready;
  logic [7:0] code = '0, attr = '0;
  logic [3:0] line = '0;
  logic blink_on = 1'b0;
  logic [2:0] base = '0;
  logic [3:0] bg = '0;
  logic [4:0] ul = '0;
  logic rd_req;
  logic [15:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic pix_valid;
  logic [3:0] pix;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  attr_text_pixgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cell_valid_i(cell_valid), .cell_ready_o(cell_ready),
    .char_code_i(code), .attr_i(attr), .scan_line_i(line), .blink_on_i(blink_on),
    .glyph_base_i(base), .bg_color_i(bg), .ul_line_i(ul), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .pix_valid_o(pix_valid), .pix_rgbi_o(pix)
  );

  function automatic logic [7:0] ram_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cell(input logic [7:0] c, input logic [7:0] a, input logic [3:0] l,
                          input bit bon, input logic [2:0] b, input logic [4:0] u, input string ultag);
    logic [15:0] exp_addr;
    logic [7:0]  row;
    logic [3:0]  fg, bgc;
    bit ulhit, blank;
    string tag;
    fg  = a[3:0];
    bgc = a[3:0] ^ 4'h9;
    chk(cell_ready === 1'b1, "R3 ready", cell_ready, 1);
    code = c; attr = a; line = l; blink_on = bon; base = b; bg = bgc; ul = u;
    cell_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cell_valid = 1'b0;
    code = ~c; attr = ~a; bg = ~bgc; blink_on = ~bon;
    exp_addr = {b, a[7], c, l};
    chk(rd_req === 1'b1, "R3 req", rd_req, 1);
    chk(rd_addr === exp_addr, "R2 addr", rd_addr, exp_addr);
    chk(cell_ready === 1'b0, "R3 busy", cell_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(rd_req === 1'b0, "R3 pulse", rd_req, 0);
    chk(pix_valid === 1'b0, "R4 wait", pix_valid, 0);
    rd_valid = 1'b1; rd_data = ram_byte(exp_addr);
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0; rd_data = 8'h00;
    row   = ram_byte(exp_addr);
    ulhit = a[5] && (u == {1'b0, l});
    blank = a[4] && !bon;
    if (ulhit) row = 8'hFF;
    if (a[6]) row = ~row;
    if (blank) row = 8'h00;
    tag = blank ? "R7 blink" : ulhit ? ultag : a[6] ? "R6 reverse" : "R4 pixel";
    for (int i = 0; i < 8; i++) begin
      logic [3:0] e;
      e = row[7-i] ? fg : bgc;
      chk(pix_valid === 1'b1, "R4 valid", pix_valid, 1);
      chk(pix === e, tag, pix, e);
      @(posedge clk); @(negedge clk);
    end
    chk(pix_valid === 1'b0, "R4 end", pix_valid, 0);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [3];
    codes[0] = 8'd0; codes[1] = 8'd65; codes[2] = 8'd255;
    #5;
    chk(rd_req === 1'b0 && pix_valid === 1'b0 && cell_ready === 1'b1, "R1 reset",
        {rd_req, pix_valid, cell_ready}, 3'b001);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req === 1'b0 && pix_valid === 1'b0 && cell_ready === 1'b1, "R1 idle",
        {rd_req, pix_valid, cell_ready}, 3'b001);
    // R2: code 65 with alternate set gives glyph 321
    run_cell(8'd65, 8'h83, 4'd2, 1'b1, 3'd1, 5'd5, "R5 underline");
    chk(rd_addr[12:4] === 9'd321, "R2 glyph321", rd_addr[12:4], 321);
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 16; s++)
        for (int bo = 0; bo < 2; bo++)
          for (int k = 0; k < 3; k++)
            run_cell(codes[k], {f[3:0], 4'(f + s + k)}, s[3:0], bo[0],
                     3'(f + k), 5'd5, "R5 underline");
    // R8: out-of-range underline line never matches
    for (int u = 16; u < 32; u += 5)
      for (int s = 0; s < 16; s++)
        run_cell(8'(s * 7), 8'h2C, s[3:0], 1'b1, 3'd6, 5'(u), "R8 ul_range");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule